// File: doc/BRIEF.md
# Character Raster Controller with Phase-Interleaved Memory Addressing

This block generates the timing for a character-cell display: horizontal and vertical sync, display enable, a cursor marker, the scan line within the current character row, and the address of each character cell in display memory. It runs on the character clock. A processor programs it through two byte locations on a small bus. The first location selects one of twenty internal registers, and the second location writes the selected register.

The memory address output is shared between two users on alternate processor clock phases. While the phase input is low, the output carries the refresh address of the cell being displayed. While the phase input is high, it carries a stored update address. The processor reaches display memory at that one address, so it never waits for blanking and no external address multiplexer is needed.

Top module: `crtc_interleave`

## Requirements
- R1: A bus write with `bus_rs`=0 loads `bus_wdata[4:0]` as the register index. A bus write with `bus_rs`=1 loads `bus_wdata` into the indexed register. A data write while the index is 20 or higher changes no register.
- R2: While `ph2`=1, `ma` carries the update address {reg18[5:0], reg19}.
- R3: The character counter counts 0 up to reg0 and then returns to 0, so a line lasts reg0+1 clocks.
- R4: `de` is 1 only while the character counter is below reg1, the row counter is below reg6[6:0], and the frame is not in its adjust lines.
- R5: `hsync` is 1 while the character counter is at least reg2 and below reg2 + reg3[3:0]. A width of 0 gives no pulse.
- R6: `ra` counts scan lines 0 to reg9[4:0], and then the row counter advances. After the last scan line of row reg4[6:0], reg5[4:0] adjust lines follow, with `ra` counting from 0. The frame then restarts at row 0.
- R7: `vsync` starts on the first scan line of row reg7[6:0], outside the adjust lines, and lasts reg3[7:4] lines. A width of 0 means 16 lines.
- R8: While `ph2`=0, `ma` is the row base plus the character counter. The row base is the start address {reg12[5:0], reg13} at each frame start and grows by reg1 on each new row.
- R9: `cursor` is 1 when the refresh address equals {reg14[5:0], reg15}, `ra` is between reg10[4:0] and reg11[4:0] inclusive, and `de` is 1.
- R10: Reset clears all registers and counters, and the outputs `hsync`, `vsync`, `de`, `cursor`, `ma` and `ra` are 0. The internal reset ends on the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_rs | input | 1 | 0 selects the index location, 1 selects the data location |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| ph2 | input | 1 | Processor clock phase; 1 gives the address lines to the update address |
| ma | output | 14 | Display memory address |
| ra | output | 5 | Scan line within the character row |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| cursor | output | 1 | Cursor marker |

## Verification
The bench tries ten randomly drawn raster formats. Each format has its own line length, sync placement and width, rows, scan lines, adjust count and cursor window, and `ph2` toggles at random on every clock. Comparing every output against a cycle model on each clock separates errors in counter wrap, the adjust lines, sync width coding and row base stepping, because each of these shows up only in some formats. Directed cases then measure one line period from `hsync`, write data through an out-of-range index and check that the update address is unchanged, and check the outputs under reset.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  parameter int REG_W = 8;
  parameter int NREG  = 20;
  parameter int IDX_W = 5;
  parameter int HCW   = 8;
  parameter int ROWW  = 7;
  parameter int SLW   = 5;
  parameter int MAW   = 14;
  parameter int HIW   = MAW - REG_W;
  parameter int VSCW  = 5;

  localparam int IX_HTOT  = 0;
  localparam int IX_HDISP = 1;
  localparam int IX_HSPOS = 2;
  localparam int IX_SYNCW = 3;
  localparam int IX_VTOT  = 4;
  localparam int IX_VADJ  = 5;
  localparam int IX_VDISP = 6;
  localparam int IX_VSPOS = 7;
  localparam int IX_MAXSL = 9;
  localparam int IX_CSTRT = 10;
  localparam int IX_CEND  = 11;
  localparam int IX_SA_HI = 12;
  localparam int IX_SA_LO = 13;
  localparam int IX_CA_HI = 14;
  localparam int IX_CA_LO = 15;
  localparam int IX_UA_HI = 18;
  localparam int IX_UA_LO = 19;

  typedef struct packed {
    logic [HCW-1:0]  h_total;
    logic [HCW-1:0]  h_disp;
    logic [HCW-1:0]  h_sync_pos;
    logic [3:0]      hs_w;
    logic [3:0]      vs_w;
    logic [ROWW-1:0] v_total;
    logic [ROWW-1:0] v_disp;
    logic [ROWW-1:0] v_sync_pos;
    logic [SLW-1:0]  v_adj;
    logic [SLW-1:0]  max_sl;
    logic [SLW-1:0]  cur_start;
    logic [SLW-1:0]  cur_end;
    logic [MAW-1:0]  start_addr;
    logic [MAW-1:0]  cur_addr;
    logic [MAW-1:0]  upd_addr;
  } crtc_cfg_t;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rs,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output crtc_cfg_t        cfg
);
  logic [IDX_W-1:0]             idx_q, idx_d;
  logic [NREG-1:0][REG_W-1:0]   regs_q, regs_d;
  logic                         wr_idx, wr_dat;

  assign wr_idx = sel && we && !rs;
  assign wr_dat = sel && we && rs;

  always_comb begin
    idx_d = idx_q;
    if (wr_idx) idx_d = wdata[IDX_W-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb begin
      regs_d[g] = regs_q[g];
      if (wr_dat && (idx_q == IDX_W'(g))) regs_d[g] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      regs_q <= '0;
    end else begin
      idx_q  <= idx_d;
      regs_q <= regs_d;
    end
  end

  always_comb begin
    cfg.h_total    = regs_q[IX_HTOT];
    cfg.h_disp     = regs_q[IX_HDISP];
    cfg.h_sync_pos = regs_q[IX_HSPOS];
    cfg.hs_w       = regs_q[IX_SYNCW][3:0];
    cfg.vs_w       = regs_q[IX_SYNCW][7:4];
    cfg.v_total    = regs_q[IX_VTOT][ROWW-1:0];
    cfg.v_adj      = regs_q[IX_VADJ][SLW-1:0];
    cfg.v_disp     = regs_q[IX_VDISP][ROWW-1:0];
    cfg.v_sync_pos = regs_q[IX_VSPOS][ROWW-1:0];
    cfg.max_sl     = regs_q[IX_MAXSL][SLW-1:0];
    cfg.cur_start  = regs_q[IX_CSTRT][SLW-1:0];
    cfg.cur_end    = regs_q[IX_CEND][SLW-1:0];
    cfg.start_addr = {regs_q[IX_SA_HI][HIW-1:0], regs_q[IX_SA_LO]};
    cfg.cur_addr   = {regs_q[IX_CA_HI][HIW-1:0], regs_q[IX_CA_LO]};
    cfg.upd_addr   = {regs_q[IX_UA_HI][HIW-1:0], regs_q[IX_UA_LO]};
  end

  AST_IGNORED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && (idx_q >= IDX_W'(NREG))) |=> $stable(regs_q)); // R1
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  crtc_cfg_t       cfg,
  output logic [HCW-1:0]  hcnt,
  output logic [SLW-1:0]  sl,
  output logic            de,
  output logic            hsync,
  output logic            vsync,
  output logic            frame_end,
  output logic            row_adv
);
  logic [HCW-1:0]  hcnt_q, hcnt_d;
  logic [SLW-1:0]  sl_q, sl_d;
  logic [ROWW-1:0] row_q, row_d;
  logic            adj_q, adj_d;
  logic [VSCW-1:0] vs_q, vs_d;
  logic            line_end;

  assign line_end = (hcnt_q == cfg.h_total);

  always_comb begin
    hcnt_d    = line_end ? '0 : hcnt_q + 1'b1;
    sl_d      = sl_q;
    row_d     = row_q;
    adj_d     = adj_q;
    frame_end = 1'b0;
    row_adv   = 1'b0;
    if (line_end) begin
      if (adj_q) begin
        if (sl_q == (cfg.v_adj - 1'b1)) frame_end = 1'b1;
        else                            sl_d = sl_q + 1'b1;
      end else if (sl_q == cfg.max_sl) begin
        if (row_q == cfg.v_total) begin
          if (cfg.v_adj == '0) frame_end = 1'b1;
          else begin
            adj_d = 1'b1;
            sl_d  = '0;
          end
        end else begin
          row_d   = row_q + 1'b1;
          sl_d    = '0;
          row_adv = 1'b1;
        end
      end else begin
        sl_d = sl_q + 1'b1;
      end
      if (frame_end) begin
        sl_d  = '0;
        row_d = '0;
        adj_d = 1'b0;
      end
    end
  end

  always_comb begin
    vs_d = vs_q;
    if (line_end) begin
      if ((row_d == cfg.v_sync_pos) && (sl_d == '0) && !adj_d)
        vs_d = (cfg.vs_w == 4'd0) ? VSCW'(16) : VSCW'(cfg.vs_w);
      else if (vs_q != '0)
        vs_d = vs_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sl_q   <= '0;
      row_q  <= '0;
      adj_q  <= 1'b0;
      vs_q   <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      sl_q   <= sl_d;
      row_q  <= row_d;
      adj_q  <= adj_d;
      vs_q   <= vs_d;
    end
  end

  assign hcnt  = hcnt_q;
  assign sl    = sl_q;
  assign de    = (hcnt_q < cfg.h_disp) && (row_q < cfg.v_disp) && !adj_q;
  assign hsync = ({1'b0, hcnt_q} >= {1'b0, cfg.h_sync_pos}) &&
                 ({1'b0, hcnt_q} < ({1'b0, cfg.h_sync_pos} + {{(HCW-3){1'b0}}, cfg.hs_w}));
  assign vsync = (vs_q != '0);

  AST_HWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q == cfg.h_total) |=> (hcnt_q == '0)); // R3
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !adj_q && (sl_q == cfg.max_sl) && (row_q != cfg.v_total))
      |=> ((row_q == $past(row_q) + 1'b1) && (sl_q == '0))); // R6
  AST_VS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> ((row_q == $past(cfg.v_sync_pos)) && (sl_q == '0) && !adj_q)); // R7
  AST_DE_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    adj_q |-> !de); // R4
endmodule

// File: rtl/crtc_addr.sv
module crtc_addr
  import crtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  crtc_cfg_t       cfg,
  input  logic [HCW-1:0]  hcnt,
  input  logic [SLW-1:0]  sl,
  input  logic            de,
  input  logic            frame_end,
  input  logic            row_adv,
  input  logic            ph2,
  output logic [MAW-1:0]  ma,
  output logic            cursor
);
  logic [MAW-1:0] base_q, base_d;
  logic [MAW-1:0] refr;

  always_comb begin
    base_d = base_q;
    if (frame_end)    base_d = cfg.start_addr;
    else if (row_adv) base_d = base_q + {{(MAW-HCW){1'b0}}, cfg.h_disp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign refr   = base_q + {{(MAW-HCW){1'b0}}, hcnt};
  assign cursor = de && (refr == cfg.cur_addr) &&
                  (sl >= cfg.cur_start) && (sl <= cfg.cur_end);
  assign ma     = ph2 ? cfg.upd_addr : refr;

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |=> (base_q == $past(base_q) + {{(MAW-HCW){1'b0}}, $past(cfg.h_disp)})); // R8
  AST_BASE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (base_q == $past(cfg.start_addr))); // R8
endmodule

// File: rtl/crtc_interleave.sv
module crtc_interleave
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_rs,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             ph2,
  output logic [MAW-1:0]   ma,
  output logic [SLW-1:0]   ra,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             cursor
);
  logic [1:0]     rsync_q;
  logic           rst_int_n;
  crtc_cfg_t      cfg;
  logic [HCW-1:0] hcnt;
  logic           frame_end, row_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  crtc_regfile u_regs (
    .clk(clk), .rst_n(rst_int_n), .sel(bus_sel), .rs(bus_rs),
    .we(bus_we), .wdata(bus_wdata), .cfg(cfg));

  crtc_timing u_tim (
    .clk(clk), .rst_n(rst_int_n), .cfg(cfg), .hcnt(hcnt), .sl(ra),
    .de(de), .hsync(hsync), .vsync(vsync),
    .frame_end(frame_end), .row_adv(row_adv));

  crtc_addr u_addr (
    .clk(clk), .rst_n(rst_int_n), .cfg(cfg), .hcnt(hcnt), .sl(ra),
    .de(de), .frame_end(frame_end), .row_adv(row_adv), .ph2(ph2),
    .ma(ma), .cursor(cursor));

  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ph2 && $past(ph2) && $stable(cfg.upd_addr)) |-> $stable(ma)); // R2
endmodule

// File: tb/sim_crtc_interleave.sv
module sim_crtc_interleave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_rs = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic        ph2 = 1'b0;
  logic [13:0] ma;
  logic [4:0]  ra;
  logic        hsync, vsync, de, cursor;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_en  = 1'b0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  crtc_interleave u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rs(bus_rs),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .ph2(ph2), .ma(ma), .ra(ra),
    .hsync(hsync), .vsync(vsync), .de(de), .cursor(cursor));

  // reference model state, built from the requirements
  logic [7:0]  sh [20];
  logic [4:0]  m_idx;
  logic [1:0]  m_rs;
  logic [7:0]  m_h;
  logic [4:0]  m_sl;
  logic [6:0]  m_row;
  logic        m_adj;
  logic [4:0]  m_vs;
  logic [13:0] m_base;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00;
      m_idx <= '0; m_h <= '0; m_sl <= '0; m_row <= '0; m_adj <= 1'b0;
      m_vs <= '0; m_base <= '0;
      for (int i = 0; i < 20; i++) sh[i] <= 8'd0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (!m_rs[1]) begin
        m_idx <= '0; m_h <= '0; m_sl <= '0; m_row <= '0; m_adj <= 1'b0;
        m_vs <= '0; m_base <= '0;
        for (int i = 0; i < 20; i++) sh[i] <= 8'd0;
      end else begin
        automatic logic [4:0] nsl = m_sl;
        automatic logic [6:0] nrow = m_row;
        automatic logic nadj = m_adj;
        automatic logic fe = 1'b0;
        automatic logic adv = 1'b0;
        if (bus_sel && bus_we && !bus_rs) m_idx <= bus_wdata[4:0];
        if (bus_sel && bus_we && bus_rs && m_idx < 5'd20) sh[m_idx] <= bus_wdata;
        if (m_h == sh[0]) begin
          m_h <= 8'd0;
          if (m_adj) begin
            if (m_sl == sh[5][4:0] - 5'd1) fe = 1'b1; else nsl = m_sl + 5'd1;
          end else if (m_sl == sh[9][4:0]) begin
            if (m_row == sh[4][6:0]) begin
              if (sh[5][4:0] == 5'd0) fe = 1'b1;
              else begin nadj = 1'b1; nsl = 5'd0; end
            end else begin
              nrow = m_row + 7'd1; nsl = 5'd0; adv = 1'b1;
            end
          end else nsl = m_sl + 5'd1;
          if (fe) begin nsl = 5'd0; nrow = 7'd0; nadj = 1'b0; end
          if (nrow == sh[7][6:0] && nsl == 5'd0 && !nadj)
            m_vs <= (sh[3][7:4] == 4'd0) ? 5'd16 : {1'b0, sh[3][7:4]};
          else if (m_vs != 5'd0) m_vs <= m_vs - 5'd1;
        end else begin
          m_h <= m_h + 8'd1;
        end
        m_sl <= nsl; m_row <= nrow; m_adj <= nadj;
        if (fe) m_base <= {sh[12][5:0], sh[13]};
        else if (adv) m_base <= m_base + {6'd0, sh[1]};
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] exp_ref();
    return m_base + {6'd0, m_h};
  endfunction
  function automatic logic exp_de();
    return (m_h < sh[1]) && (m_row < sh[6][6:0]) && !m_adj;
  endfunction

  always @(negedge clk) begin
    if (chk_en) begin
      automatic logic [13:0] r = exp_ref();
      automatic logic d = exp_de();
      automatic logic hs = ({1'b0, m_h} >= {1'b0, sh[2]}) &&
                           ({1'b0, m_h} < ({1'b0, sh[2]} + {5'd0, sh[3][3:0]}));
      automatic logic cu = d && (r == {sh[14][5:0], sh[15]}) &&
                           (m_sl >= sh[10][4:0]) && (m_sl <= sh[11][4:0]);
      if (ph2) chk("R2 ma update", ma, {sh[18][5:0], sh[19]});
      else     chk("R8 ma refresh", ma, r);
      chk("R4 de", de, d);
      chk("R5 hsync", hsync, hs);
      chk("R7 vsync", vsync, m_vs != 5'd0);
      chk("R9 cursor", cursor, cu);
      chk("R6 ra", ra, m_sl);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    bus_sel = 1'b1; bus_we = 1'b1; bus_rs = 1'b0; bus_wdata = idx;
    tick();
    bus_rs = 1'b1; bus_wdata = val;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0; bus_rs = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] cfg [20];
    int period, t0;
    void'($urandom(32'd4242));
    // R10: outputs while reset is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset ma", ma, 0);
    chk("R10 reset de", de, 0);
    chk("R10 reset hsync", hsync, 0);
    chk("R10 reset vsync", vsync, 0);
    chk("R10 reset cursor", cursor, 0);
    chk("R10 reset ra", ra, 0);
    chk_en = 1'b1;
    tick(); rst_n = 1'b1;
    repeat (4) tick();

    // R3: directed line length measured from hsync
    wr(8'd0, 8'd19); wr(8'd2, 8'd5); wr(8'd3, 8'h21); wr(8'd1, 8'd10);
    repeat (25) tick();
    @(negedge clk); while (!hsync) @(negedge clk);
    @(negedge clk); while (hsync) @(negedge clk);
    t0 = 0; while (!hsync) begin @(negedge clk); t0++; end
    period = t0 + 1;
    chk("R3 line period", period, 20);

    // R1: out-of-range index leaves the update address unchanged
    tick();
    wr(8'd18, 8'h05); wr(8'd19, 8'h34);
    wr(8'd25, 8'hFF); wr(8'd31, 8'h77);
    ph2 = 1'b1; tick();
    @(negedge clk);
    chk("R1 ignored index", ma, 14'h0534);
    tick(); ph2 = 1'b0;

    // randomized raster formats
    for (int k = 0; k < 10; k++) begin
      cfg[0]  = 8'(8 + $urandom_range(0, 22));
      cfg[1]  = 8'($urandom_range(1, cfg[0]));
      cfg[2]  = 8'($urandom_range(0, cfg[0]));
      cfg[3]  = 8'($urandom_range(0, 255));
      cfg[4]  = 8'($urandom_range(1, 5));
      cfg[5]  = 8'($urandom_range(0, 3));
      cfg[6]  = 8'($urandom_range(0, cfg[4] + 1));
      cfg[7]  = 8'($urandom_range(0, cfg[4]));
      cfg[8]  = 8'd0;
      cfg[9]  = 8'($urandom_range(0, 7));
      cfg[10] = 8'($urandom_range(0, 3));
      cfg[11] = 8'($urandom_range(cfg[10], 7));
      cfg[12] = 8'($urandom_range(0, 63));
      cfg[13] = 8'($urandom_range(0, 255));
      cfg[14] = cfg[12];
      cfg[15] = 8'(cfg[13] + cfg[1] + 8'd2);
      cfg[16] = 8'd0; cfg[17] = 8'd0;
      cfg[18] = 8'($urandom_range(0, 255));
      cfg[19] = 8'($urandom_range(0, 255));
      for (int i = 0; i < 20; i++) wr(8'(i), cfg[i]);
      for (int c = 0; c < 3500; c++) begin
        ph2 = 1'($urandom_range(0, 1));
        tick();
      end
      wr(8'd19, 8'($urandom_range(0, 255)));
      ph2 = 1'b1; repeat (3) tick(); ph2 = 1'b0;
    end

    repeat (2) tick();
    chk_en = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule